// File: doc/BRIEF.md
# Synchronous Receiver Character Alignment Hunt

This block takes a synchronous serial bit stream and finds character boundaries before it assembles characters. A bit is taken from `ser_in` on each clock cycle in which `bit_en` is high. Serial bits arrive least significant first.

After reset, or after a host restart command, the block is in hunt state. In internal mode it compares the most recent character-length window against a programmed sync pattern on every received bit. It can match one sync pattern, or a pair of patterns that must arrive back to back. In external mode the comparator is ignored and a rising edge on an external input gives the alignment.

Once alignment is found, the block raises a sticky sync-found flag. From then on it frames a character every N bits and presents each one with a valid flag. The host reads a character with `data_rd` and reads status with `status_rd`.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, `hunting` is 1 and `sync_found`, `char_valid` and `overrun` are 0.
- R2: Character length N is 5 + `len_sel` (0 gives 5 bits, 3 gives 8 bits).
  - In internal mode with `two_sync`=0 and `hunting`=1, the bit whose arrival makes the last N received bits equal the low N bits of `sync_a` sets `sync_found` and clears `hunting` in that cycle.
  - The oldest bit of the window compares with bit 0, and upper bits of `sync_a` are ignored.
- R3: After alignment, every N-th received bit completes a character.
  - `rx_data` then holds the character with its first received bit in bit 0 and zeros above bit N-1.
  - `char_valid` rises in the same cycle.
  - No character is delivered while hunting.
- R4: With `two_sync`=1, alignment is declared only when the N bits right after a `sync_a` match equal `sync_b`. Even a single bit between them prevents detection.
- R5: `hunt_cmd` sets `hunting`, clears `sync_found` and any half-finished pair match, and fills the receive shift register with ones, so bits received before the command cannot complete a match.
- R6: With `ext_mode`=1, sync pattern matches have no effect.
  - A rising edge of `ext_sync_in` sets `sync_found`.
  - If `hunting` is 1, that edge also ends the hunt, and framing starts with the next received bit.
- R7: `status_rd` clears `sync_found` in the next cycle, unless a new detection occurs in the same cycle, in which case the flag stays set.
- R8: `data_rd` clears `char_valid`. If a character completes in the same cycle, `char_valid` stays 1, `rx_data` takes the new character, and no overrun is flagged.
- R9: A character that completes while `char_valid` is 1 and `data_rd` is 0 sets `overrun` and replaces `rx_data`. `overrun` then holds until `status_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Take one bit from `ser_in` this cycle |
| ser_in | input | 1 | Serial data, least significant bit first |
| len_sel | input | 2 | Character length select, N = 5 + value |
| two_sync | input | 1 | Require two consecutive sync patterns |
| ext_mode | input | 1 | Use the external sync input instead of the comparator |
| sync_a | input | W | First (or only) sync pattern |
| sync_b | input | W | Second sync pattern |
| ext_sync_in | input | 1 | External sync indication, rising edge active |
| hunt_cmd | input | 1 | Restart the hunt |
| status_rd | input | 1 | Host status read strobe |
| data_rd | input | 1 | Host character read strobe |
| rx_data | output | W | Last framed character |
| char_valid | output | 1 | Unread character present |
| sync_found | output | 1 | Sticky alignment flag |
| overrun | output | 1 | Character lost before being read |
| hunting | output | 1 | Block is searching for alignment |

## Verification
Two collisions matter most, because each pits a set against a clear.

The first is a host character read landing in the same cycle as the last bit of the next character. The bench raises `data_rd` together with that final `bit_en`. It then expects `char_valid` still high, `rx_data` holding the new character, and `overrun` still clear.

The second is a status read that coincides with an external sync rising edge. The bench expects `sync_found` to come out set, and to clear only on a later read.

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         ser_in,
  input  logic [1:0]   len_sel,
  input  logic         two_sync,
  input  logic         ext_mode,
  input  logic [W-1:0] sync_a,
  input  logic [W-1:0] sync_b,
  input  logic         ext_sync_in,
  input  logic         hunt_cmd,
  input  logic         status_rd,
  input  logic         data_rd,
  output logic [W-1:0] rx_data,
  output logic         char_valid,
  output logic         sync_found,
  output logic         overrun,
  output logic         hunting
);

  localparam int CW = $clog2(W) + 1;

  logic [W-1:0]  sr, nxt, win, msk;
  logic [CW-1:0] nbits, shamt, cnt;
  logic          stage, ext_q, last, hit_a, hit_b;
  logic          ext_rise, int_hit, syn_set, done;

  assign nbits    = CW'(5) + CW'(len_sel);
  assign shamt    = CW'(W) - nbits;
  assign nxt      = {ser_in, sr[W-1:1]};
  assign win      = nxt >> shamt;
  assign msk      = {W{1'b1}} >> shamt;
  assign hit_a    = win == (sync_a & msk);
  assign hit_b    = win == (sync_b & msk);
  assign last     = cnt == nbits - CW'(1);
  assign ext_rise = ext_sync_in & ~ext_q;

  assign int_hit = bit_en & hunting & ~ext_mode & ~hunt_cmd &
                   ((~two_sync & hit_a) | (two_sync & stage & last & hit_b));
  assign syn_set = ~hunt_cmd & (int_hit | (ext_mode & ext_rise));
  assign done    = bit_en & ~hunting & ~hunt_cmd & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '1;
      hunting <= 1'b1;
      stage   <= 1'b0;
      cnt     <= '0;
      ext_q   <= 1'b0;
    end else begin
      ext_q <= ext_sync_in;
      if (hunt_cmd) begin
        sr      <= '1;
        hunting <= 1'b1;
        stage   <= 1'b0;
        cnt     <= '0;
      end else if (ext_mode && ext_rise && hunting) begin
        if (bit_en) sr <= nxt;
        hunting <= 1'b0;
        stage   <= 1'b0;
        cnt     <= '0;
      end else if (bit_en) begin
        sr <= nxt;
        if (!hunting) begin
          cnt <= last ? '0 : cnt + CW'(1);
        end else if (!ext_mode) begin
          if (int_hit) begin
            hunting <= 1'b0;
            stage   <= 1'b0;
            cnt     <= '0;
          end else if (two_sync && stage) begin
            if (last) begin
              stage <= hit_a;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end else if (two_sync && hit_a) begin
            stage <= 1'b1;
            cnt   <= '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_found <= 1'b0;
      char_valid <= 1'b0;
      overrun    <= 1'b0;
      rx_data    <= '0;
    end else begin
      if (hunt_cmd)       sync_found <= 1'b0;
      else if (syn_set)   sync_found <= 1'b1;
      else if (status_rd) sync_found <= 1'b0;

      if (done) begin
        rx_data    <= win;
        char_valid <= 1'b1;
      end else if (data_rd) begin
        char_valid <= 1'b0;
      end

      if (done && char_valid && !data_rd) overrun <= 1'b1;
      else if (status_rd)                 overrun <= 1'b0;
    end
  end

  // R3
  rdy_from_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(char_valid) |-> !$past(hunting));

  // R5
  hunt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hunt_cmd) |-> (hunting && sr == '1 && !sync_found && !stage));

  // R6
  ext_no_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sync_found) && $past(ext_mode)) |-> $past(ext_rise));

  // R4
  pair_needs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sync_found) && $past(!ext_mode && two_sync)) |-> $past(stage));

  // R7
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_rd) && !$past(syn_set)) |-> !sync_found);

  // R9
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($past(char_valid) && !$past(data_rd)));

endmodule

// File: tb/test_sync_hunt_rx.sv
module test_sync_hunt_rx;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, ser_in = 1'b1;
  logic [1:0] len_sel = 2'd3;
  logic two_sync = 1'b0, ext_mode = 1'b0;
  logic [W-1:0] sync_a = '0, sync_b = '0;
  logic ext_sync_in = 1'b0, hunt_cmd = 1'b0, status_rd = 1'b0, data_rd = 1'b0;
  logic [W-1:0] rx_data;
  logic char_valid, sync_found, overrun, hunting;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sync_hunt_rx #(.W(W)) i_sync_hunt_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in),
    .len_sel(len_sel), .two_sync(two_sync), .ext_mode(ext_mode),
    .sync_a(sync_a), .sync_b(sync_b), .ext_sync_in(ext_sync_in),
    .hunt_cmd(hunt_cmd), .status_rd(status_rd), .data_rd(data_rd),
    .rx_data(rx_data), .char_valid(char_valid), .sync_found(sync_found),
    .overrun(overrun), .hunting(hunting));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_in = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; ser_in = 1'b1;
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  task automatic do_hunt();
    hunt_cmd = 1'b1; @(negedge clk); hunt_cmd = 1'b0;
  endtask

  task automatic pulse_status();
    status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
  endtask

  task automatic pulse_data();
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 hunting", hunting, 1);
    chk("R1 sync_found", sync_found, 0);
    chk("R1 char_valid", char_valid, 0);
    chk("R1 overrun", overrun, 0);
  endtask

  task automatic t_single();
    len_sel = 2'd3; two_sync = 0; ext_mode = 0; sync_a = 8'h16;
    do_hunt();
    send_bits(8'hFF, 5);
    send_bits(8'h16, 7);
    chk("R2 no early match", sync_found, 0);
    send_bit(1'b0);
    chk("R2 sync_found", sync_found, 1);
    chk("R2 hunt ended", hunting, 0);
    send_bits(8'hA5, 7);
    chk("R3 not yet valid", char_valid, 0);
    send_bit(1'b1);
    chk("R3 valid", char_valid, 1);
    chk("R3 data 8 bit", rx_data, 8'hA5);
    pulse_data();
    chk("R8 read clears valid", char_valid, 0);
    pulse_status();
    chk("R7 status clears flag", sync_found, 0);
  endtask

  task automatic t_len5();
    len_sel = 2'd0; sync_a = 8'hF5;
    do_hunt();
    send_bits(8'hFF, 3);
    send_bits(8'h15, 5);
    chk("R2 5-bit match", sync_found, 1);
    send_bits(8'h0B, 5);
    chk("R3 5-bit valid", char_valid, 1);
    chk("R3 5-bit data", rx_data, 8'h0B);
    pulse_data();
    len_sel = 2'd3;
  endtask

  task automatic t_stale();
    sync_a = 8'h3C;
    do_hunt();
    send_bits(8'h3C, 7);
    do_hunt();
    chk("R5 hunting", hunting, 1);
    chk("R5 flag cleared", sync_found, 0);
    send_bit(1'b0);
    chk("R5 stale bits no match", sync_found, 0);
    send_bits(8'h3C, 8);
    chk("R5 fresh match", sync_found, 1);
  endtask

  task automatic t_double();
    two_sync = 1; sync_a = 8'h16; sync_b = 8'h32;
    do_hunt();
    send_bits(8'hFF, 3);
    send_bits(8'h16, 8);
    chk("R4 first alone", sync_found, 0);
    send_bit(1'b0);
    send_bits(8'h32, 8);
    chk("R4 gap rejects", sync_found, 0);
    chk("R4 still hunting", hunting, 1);
    do_hunt();
    send_bits(8'h16, 8);
    send_bits(8'h32, 8);
    chk("R4 pair match", sync_found, 1);
    chk("R4 hunt ended", hunting, 0);
    send_bits(8'h81, 8);
    chk("R3 data after pair", rx_data, 8'h81);
    pulse_data();
    pulse_status();
    two_sync = 0;
  endtask

  task automatic t_ext();
    ext_mode = 1; sync_a = 8'h16;
    do_hunt();
    send_bits(8'hFF, 2);
    send_bits(8'h16, 8);
    chk("R6 comparator off", sync_found, 0);
    chk("R6 still hunting", hunting, 1);
    ext_sync_in = 1; status_rd = 1;
    @(negedge clk);
    status_rd = 0;
    chk("R7 set wins over read", sync_found, 1);
    chk("R6 edge ends hunt", hunting, 0);
    @(negedge clk);
    chk("R6 flag held", sync_found, 1);
    pulse_status();
    chk("R7 flag cleared by read", sync_found, 0);
    @(negedge clk);
    chk("R6 level not an edge", sync_found, 0);
    send_bits(8'h5A, 8);
    chk("R6 framed valid", char_valid, 1);
    chk("R6 framed data", rx_data, 8'h5A);
    pulse_data();
    ext_sync_in = 0; ext_mode = 0;
  endtask

  task automatic t_overrun();
    send_bits(8'h11, 8);
    chk("R3 first char", rx_data, 8'h11);
    send_bits(8'h22, 8);
    chk("R9 overrun set", overrun, 1);
    chk("R9 data replaced", rx_data, 8'h22);
    pulse_status();
    chk("R9 overrun cleared", overrun, 0);
    chk("R9 valid kept", char_valid, 1);
    send_bits(8'h33, 7);
    data_rd = 1;
    send_bit(1'b0);
    data_rd = 0;
    chk("R8 valid stays", char_valid, 1);
    chk("R8 new data", rx_data, 8'h33);
    chk("R8 no overrun", overrun, 0);
    pulse_data();
    chk("R8 read clears", char_valid, 0);
    do_hunt();
    chk("R5 restart while framing", hunting, 1);
    send_bits(8'h44, 8);
    chk("R3 no char while hunting", char_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_len5();
    t_stale();
    t_double();
    t_ext();
    t_overrun();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule